// File: doc/BRIEF.md
# Single-Cycle Seven-Instruction Processor Core

This block is a 32-bit processor core that completes one instruction per clock cycle. On each rising edge it fetches the word addressed by its program counter from a local instruction store, decodes it into a small set of control points, reads two registers, runs a three-function ALU, optionally accesses a local data store and writes the result back. The program counter, the register file and the data store all update on the same edge.

Seven operations are executed: register add and subtract, OR with a zero-extended immediate, word load, word store, branch when two registers are equal, and an absolute jump. Every other encoding behaves as a no-op that only moves to the next word. Before a program runs, the instruction store is filled through a simple load port, normally while reset is held. The register-write, store and program-counter activity of the current instruction is visible on output ports, so the surrounding logic can follow execution without reaching inside.

Top module: `sc_core`

## Requirements
- R1: While `rst_n` is low, the program counter, all 32 registers and all data-store words are cleared, so the first instruction after reset executes at address 0 and reads zero from every register.
- R2: Opcode 000000 with function field (bits 5:0) 100000 writes R[rs]+R[rt] to register rd; with function field 100010 it writes R[rs]-R[rt] to rd. Fields: opcode 31:26, rs 25:21, rt 20:16, rd 15:11.
- R3: Opcode 001101 writes R[rs] OR the zero-extended 16-bit immediate (bits 15:0) to register rt.
- R4: Opcode 100011 writes the data-store word at R[rs] plus the sign-extended immediate to register rt; `dm_addr_o` shows that effective address.
- R5: Opcode 101011 writes R[rt] to the data-store word at R[rs] plus the sign-extended immediate, asserts `dm_we_o`, and writes no register.
- R6: Opcode 000100 sets the next PC to PC+4+(sign-extended immediate shifted left by 2) when R[rs] equals R[rt], and to PC+4 otherwise; it writes neither a register nor the data store.
- R7: Opcode 000010 sets the next PC to the upper 4 bits of PC+4, then the 26-bit field in bits 25:0, then two zero bits; it writes nothing.
- R8: Register 0 reads as zero at all times; a write addressed to it is dropped.
- R9: Every instruction other than a taken branch or a jump advances the PC by 4. Any other opcode, and opcode 000000 with any other function code, writes nothing.
- R10: The instruction store is indexed by PC bits above bit 1 modulo its depth, and the data store by effective-address bits above bit 1 modulo its depth; the two lowest address bits are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, all state updates on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_en | input | 1 | Write enable of the instruction-store load port |
| ld_addr | input | $clog2(IMEM_WORDS) | Word index written by the load port |
| ld_data | input | 32 | Instruction word written by the load port |
| pc_o | output | 32 | Address of the instruction executing this cycle |
| rf_we_o | output | 1 | Current instruction writes a register |
| rf_waddr_o | output | 5 | Destination register of the current instruction |
| rf_wdata_o | output | 32 | Value written to the destination register |
| dm_we_o | output | 1 | Current instruction writes the data store |
| dm_addr_o | output | 32 | Effective address of the current load or store |
| dm_wdata_o | output | 32 | Value written by the current store |

## Verification
A wrong program counter shows on `pc_o` in the cycle right after the faulty instruction, and a decoding error shows at once on the write-enable, write-address and write-data outputs of that same instruction. Corruption of a register or data-store word stays hidden until a later instruction reads it, so the bench runs an instruction-level model in lockstep and compares every port each cycle, which catches such damage at the first dependent read. Random programs are mixed with a directed one that hits negative offsets, address aliasing, writes to register 0, taken and untaken branches, a jump and undefined encodings.

// File: rtl/sc_pkg.sv
package sc_pkg;

    localparam int unsigned XLEN    = 32;
    localparam int unsigned NREGS   = 32;
    localparam int unsigned RIDX_W  = $clog2(NREGS);
    localparam int unsigned OPC_W   = 6;
    localparam int unsigned IMM_W   = 16;
    localparam int unsigned JTGT_W  = 26;

    localparam logic [OPC_W-1:0] OPC_REG  = 6'b000000;
    localparam logic [OPC_W-1:0] OPC_ORI  = 6'b001101;
    localparam logic [OPC_W-1:0] OPC_LDW  = 6'b100011;
    localparam logic [OPC_W-1:0] OPC_STW  = 6'b101011;
    localparam logic [OPC_W-1:0] OPC_BEQ  = 6'b000100;
    localparam logic [OPC_W-1:0] OPC_JMP  = 6'b000010;

    localparam logic [OPC_W-1:0] FN_ADD   = 6'b100000;
    localparam logic [OPC_W-1:0] FN_SUB   = 6'b100010;

    typedef enum logic [1:0] {
        ALU_ADD = 2'd0,
        ALU_SUB = 2'd1,
        ALU_OR  = 2'd2
    } alu_op_e;

    // Control word produced by the decoder, one bit per datapath choice.
    typedef struct packed {
        logic    wr_sel_rd;    // destination from rd field, else rt field
        logic    b_from_imm;   // ALU second operand from immediate
        logic    wb_from_mem;  // write-back value from data store
        logic    reg_wr;       // register file write
        logic    mem_wr;       // data store write
        logic    branch;       // conditional branch on equality
        logic    jump;         // absolute jump
        logic    ext_sign;     // sign-extend immediate, else zero-extend
        alu_op_e alu_op;
    } ctrl_t;

endpackage

// File: rtl/sc_decode.sv
module sc_decode
    import sc_pkg::*;
(
    input  logic [OPC_W-1:0] opcode_i,
    input  logic [OPC_W-1:0] funct_i,
    output ctrl_t            ctrl_o
);

    always_comb begin
        ctrl_o        = '0;
        ctrl_o.alu_op = ALU_ADD;
        unique case (opcode_i)
            OPC_REG: begin
                if (funct_i == FN_ADD) begin
                    ctrl_o.wr_sel_rd = 1'b1;
                    ctrl_o.reg_wr    = 1'b1;
                    ctrl_o.alu_op    = ALU_ADD;
                end else if (funct_i == FN_SUB) begin
                    ctrl_o.wr_sel_rd = 1'b1;
                    ctrl_o.reg_wr    = 1'b1;
                    ctrl_o.alu_op    = ALU_SUB;
                end
            end
            OPC_ORI: begin
                ctrl_o.b_from_imm = 1'b1;
                ctrl_o.reg_wr     = 1'b1;
                ctrl_o.ext_sign   = 1'b0;
                ctrl_o.alu_op     = ALU_OR;
            end
            OPC_LDW: begin
                ctrl_o.b_from_imm  = 1'b1;
                ctrl_o.wb_from_mem = 1'b1;
                ctrl_o.reg_wr      = 1'b1;
                ctrl_o.ext_sign    = 1'b1;
                ctrl_o.alu_op      = ALU_ADD;
            end
            OPC_STW: begin
                ctrl_o.b_from_imm = 1'b1;
                ctrl_o.mem_wr     = 1'b1;
                ctrl_o.ext_sign   = 1'b1;
                ctrl_o.alu_op     = ALU_ADD;
            end
            OPC_BEQ: begin
                ctrl_o.branch = 1'b1;
                ctrl_o.alu_op = ALU_SUB;
            end
            OPC_JMP: begin
                ctrl_o.jump = 1'b1;
            end
            default: begin
                ctrl_o = '0;
            end
        endcase
    end

endmodule

// File: rtl/sc_regfile.sv
module sc_regfile
    import sc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [RIDX_W-1:0] ra_a_i,
    input  logic [RIDX_W-1:0] ra_b_i,
    input  logic              we_i,
    input  logic [RIDX_W-1:0] wa_i,
    input  logic [XLEN-1:0]   wd_i,
    output logic [XLEN-1:0]   rd_a_o,
    output logic [XLEN-1:0]   rd_b_o
);

    typedef logic [XLEN-1:0] regs_t [NREGS];

    regs_t regs_d;
    regs_t regs_q;

    always_comb begin
        regs_d = regs_q;
        if (we_i && (wa_i != '0)) begin
            regs_d[wa_i] = wd_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NREGS; i++) begin
                regs_q[i] <= '0;
            end
        end else begin
            regs_q <= regs_d;
        end
    end

    assign rd_a_o = regs_q[ra_a_i];
    assign rd_b_o = regs_q[ra_b_i];

    AST_R0_STAYS_ZERO: assert property (@(posedge clk) disable iff (!rst_n) regs_q[0] == '0); // R8

endmodule

// File: rtl/sc_alu.sv
module sc_alu
    import sc_pkg::*;
(
    input  logic [XLEN-1:0] a_i,
    input  logic [XLEN-1:0] b_i,
    input  alu_op_e         op_i,
    output logic [XLEN-1:0] y_o,
    output logic            zero_o
);

    always_comb begin
        unique case (op_i)
            ALU_ADD: y_o = a_i + b_i;
            ALU_SUB: y_o = a_i - b_i;
            ALU_OR:  y_o = a_i | b_i;
            default: y_o = '0;
        endcase
    end

    assign zero_o = (y_o == '0);

endmodule

// File: rtl/sc_dmem.sv
module sc_dmem
    import sc_pkg::*;
#(
    parameter int unsigned WORDS = 64
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            we_i,
    input  logic [XLEN-1:0] addr_i,
    input  logic [XLEN-1:0] wd_i,
    output logic [XLEN-1:0] rd_o
);

    localparam int unsigned DAW = $clog2(WORDS);

    typedef logic [XLEN-1:0] words_t [WORDS];

    words_t         mem_d;
    words_t         mem_q;
    logic [DAW-1:0] idx;
    logic           unused_addr_bits;

    assign idx              = addr_i[DAW+1:2];
    assign unused_addr_bits = ^{addr_i[1:0], addr_i[XLEN-1:DAW+2]};

    always_comb begin
        mem_d = mem_q;
        if (we_i) begin
            mem_d[idx] = wd_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < WORDS; i++) begin
                mem_q[i] <= '0;
            end
        end else begin
            mem_q <= mem_d;
        end
    end

    assign rd_o = mem_q[idx];

endmodule

// File: rtl/sc_core.sv
module sc_core
    import sc_pkg::*;
#(
    parameter int unsigned IMEM_WORDS = 64,
    parameter int unsigned DMEM_WORDS = 64
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          ld_en,
    input  logic [$clog2(IMEM_WORDS)-1:0] ld_addr,
    input  logic [XLEN-1:0]               ld_data,
    output logic [XLEN-1:0]               pc_o,
    output logic                          rf_we_o,
    output logic [RIDX_W-1:0]             rf_waddr_o,
    output logic [XLEN-1:0]               rf_wdata_o,
    output logic                          dm_we_o,
    output logic [XLEN-1:0]               dm_addr_o,
    output logic [XLEN-1:0]               dm_wdata_o
);

    localparam int unsigned IAW = $clog2(IMEM_WORDS);

    typedef struct packed {
        logic [XLEN-1:0] pc;
    } core_state_t;

    core_state_t state_d;
    core_state_t state_q;

    // Instruction store, written only through the load port.
    logic [XLEN-1:0] imem_q [IMEM_WORDS];

    always_ff @(posedge clk) begin
        if (ld_en) begin
            imem_q[ld_addr] <= ld_data;
        end
    end

    logic [XLEN-1:0]   instr;
    logic [OPC_W-1:0]  f_opc;
    logic [RIDX_W-1:0] f_rs;
    logic [RIDX_W-1:0] f_rt;
    logic [RIDX_W-1:0] f_rd;
    logic [OPC_W-1:0]  f_fn;
    logic [IMM_W-1:0]  f_imm;
    logic [JTGT_W-1:0] f_tgt;
    logic              unused_shamt;

    assign instr        = imem_q[state_q.pc[IAW+1:2]];
    assign f_opc        = instr[31:26];
    assign f_rs         = instr[25:21];
    assign f_rt         = instr[20:16];
    assign f_rd         = instr[15:11];
    assign f_fn         = instr[5:0];
    assign f_imm        = instr[15:0];
    assign f_tgt        = instr[25:0];
    assign unused_shamt = ^instr[10:6];

    ctrl_t ctrl;

    sc_decode u_dec (
        .opcode_i (f_opc),
        .funct_i  (f_fn),
        .ctrl_o   (ctrl)
    );

    logic [RIDX_W-1:0] wr_idx;
    logic [XLEN-1:0]   rd_a;
    logic [XLEN-1:0]   rd_b;
    logic [XLEN-1:0]   wb_val;

    assign wr_idx = ctrl.wr_sel_rd ? f_rd : f_rt;

    sc_regfile u_rf (
        .clk    (clk),
        .rst_n  (rst_n),
        .ra_a_i (f_rs),
        .ra_b_i (f_rt),
        .we_i   (ctrl.reg_wr),
        .wa_i   (wr_idx),
        .wd_i   (wb_val),
        .rd_a_o (rd_a),
        .rd_b_o (rd_b)
    );

    logic [XLEN-1:0] imm_sx;
    logic [XLEN-1:0] imm_ext;
    logic [XLEN-1:0] alu_b;
    logic [XLEN-1:0] alu_y;
    logic            alu_zero;

    assign imm_sx  = {{(XLEN-IMM_W){f_imm[IMM_W-1]}}, f_imm};
    assign imm_ext = ctrl.ext_sign ? imm_sx : {{(XLEN-IMM_W){1'b0}}, f_imm};
    assign alu_b   = ctrl.b_from_imm ? imm_ext : rd_b;

    sc_alu u_alu (
        .a_i    (rd_a),
        .b_i    (alu_b),
        .op_i   (ctrl.alu_op),
        .y_o    (alu_y),
        .zero_o (alu_zero)
    );

    logic [XLEN-1:0] dm_rdata;

    sc_dmem #(
        .WORDS (DMEM_WORDS)
    ) u_dm (
        .clk    (clk),
        .rst_n  (rst_n),
        .we_i   (ctrl.mem_wr),
        .addr_i (alu_y),
        .wd_i   (rd_b),
        .rd_o   (dm_rdata)
    );

    assign wb_val = ctrl.wb_from_mem ? dm_rdata : alu_y;

    // Next program counter.
    logic [XLEN-1:0] pc_seq;
    logic [XLEN-1:0] pc_br;
    logic [XLEN-1:0] pc_jmp;

    assign pc_seq = state_q.pc + XLEN'(4);
    assign pc_br  = pc_seq + {imm_sx[XLEN-3:0], 2'b00};
    assign pc_jmp = {pc_seq[XLEN-1:XLEN-4], f_tgt, 2'b00};

    always_comb begin
        state_d = state_q;
        if (ctrl.jump) begin
            state_d.pc = pc_jmp;
        end else if (ctrl.branch && alu_zero) begin
            state_d.pc = pc_br;
        end else begin
            state_d.pc = pc_seq;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign pc_o       = state_q.pc;
    assign rf_we_o    = ctrl.reg_wr;
    assign rf_waddr_o = wr_idx;
    assign rf_wdata_o = wb_val;
    assign dm_we_o    = ctrl.mem_wr;
    assign dm_addr_o  = alu_y;
    assign dm_wdata_o = rd_b;

    AST_SEQ_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n) !(ctrl.branch || ctrl.jump) |=> state_q.pc == $past(state_q.pc) + XLEN'(4)); // R9
    AST_BRANCH_NOT_TAKEN: assert property (@(posedge clk) disable iff (!rst_n) (ctrl.branch && (rd_a != rd_b)) |=> state_q.pc == $past(state_q.pc) + XLEN'(4)); // R6
    AST_JUMP_FIELD: assert property (@(posedge clk) disable iff (!rst_n) ctrl.jump |=> state_q.pc[JTGT_W+1:2] == $past(f_tgt)); // R7
    AST_LOAD_WRITEBACK: assert property (@(posedge clk) disable iff (!rst_n) ctrl.wb_from_mem |-> (ctrl.reg_wr && !ctrl.mem_wr)); // R4
    AST_ONE_EFFECT: assert property (@(posedge clk) disable iff (!rst_n) $onehot0({ctrl.branch, ctrl.jump, ctrl.mem_wr, ctrl.reg_wr})); // R5

endmodule

// File: tb/tb_sc_core.sv
`timescale 1ns/1ps
module tb_sc_core;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        ld_en;
    logic [5:0]  ld_addr;
    logic [31:0] ld_data;
    logic [31:0] pc_o;
    logic        rf_we_o;
    logic [4:0]  rf_waddr_o;
    logic [31:0] rf_wdata_o;
    logic        dm_we_o;
    logic [31:0] dm_addr_o;
    logic [31:0] dm_wdata_o;

    always #2.5 clk = ~clk;

    sc_core dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .ld_en      (ld_en),
        .ld_addr    (ld_addr),
        .ld_data    (ld_data),
        .pc_o       (pc_o),
        .rf_we_o    (rf_we_o),
        .rf_waddr_o (rf_waddr_o),
        .rf_wdata_o (rf_wdata_o),
        .dm_we_o    (dm_we_o),
        .dm_addr_o  (dm_addr_o),
        .dm_wdata_o (dm_wdata_o)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    logic [31:0] m_reg  [32];
    logic [31:0] m_dmem [64];
    logic [31:0] m_imem [64];
    logic [31:0] m_pc;
    string       prev_tag;

    localparam logic [31:0] NOP_WORD = 32'hFC00_0000;

    function automatic logic [31:0] enc_r(input logic [4:0] rs, input logic [4:0] rt,
                                          input logic [4:0] rd, input logic [5:0] fn);
        return {6'b000000, rs, rt, rd, 5'd0, fn};
    endfunction

    function automatic logic [31:0] enc_i(input logic [5:0] op, input logic [4:0] rs,
                                          input logic [4:0] rt, input logic [15:0] imm);
        return {op, rs, rt, imm};
    endfunction

    function automatic logic [31:0] enc_j(input logic [25:0] tgt);
        return {6'b000010, tgt};
    endfunction

    function automatic logic [31:0] rand_instr();
        int unsigned k  = $urandom % 10;
        logic [4:0]  rs = 5'($urandom % 8);
        logic [4:0]  rt = 5'($urandom % 8);
        logic [4:0]  rd = 5'($urandom % 8);
        logic [15:0] im = 16'($urandom);
        case (k)
            0: return enc_r(rs, rt, rd, 6'b100000);
            1: return enc_r(rs, rt, rd, 6'b100010);
            2, 3: return enc_i(6'b001101, rs, rt, im);
            4: return enc_i(6'b100011, rs, rt, im);
            5: return enc_i(6'b101011, rs, rt, im);
            6: return enc_i(6'b000100, rs, rt, 16'($signed(5'($urandom))));
            7: return enc_j(26'($urandom));
            8: return {2'b11, 4'($urandom), 26'($urandom)};
            default: return enc_r(rs, rt, rd, 6'b100101);
        endcase
    endfunction

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s at t=%0t: actual %h expected %h", req, what, $time, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < 32; i++) m_reg[i] = '0;
        for (int i = 0; i < 64; i++) m_dmem[i] = '0;
        m_pc     = '0;
        prev_tag = "R1";
    endtask

    // Reset the design, load the model program into it, release at a falling edge.
    task automatic reset_and_load();
        @(negedge clk);
        rst_n = 1'b0;
        model_reset();
        for (int i = 0; i < 64; i++) begin
            ld_en   = 1'b1;
            ld_addr = 6'(i);
            ld_data = m_imem[i];
            @(negedge clk);
        end
        ld_en = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        chk("R1", "pc after reset", pc_o, 32'd0);
    endtask

    // Compare the ports for the instruction now executing, then advance the model.
    task automatic step_check();
        logic [31:0] ins, a, b, sx, zx, ea, pc4, npc, wd, dad, dwd;
        logic [5:0]  op, fn;
        logic [4:0]  rs, rt, rd, wa;
        bit          ewe, dwe;
        string       tag;
        ins = m_imem[m_pc[7:2]];
        op  = ins[31:26]; rs = ins[25:21]; rt = ins[20:16]; rd = ins[15:11]; fn = ins[5:0];
        sx  = {{16{ins[15]}}, ins[15:0]};
        zx  = {16'd0, ins[15:0]};
        a   = m_reg[rs]; b = m_reg[rt];
        pc4 = m_pc + 32'd4; npc = pc4;
        ewe = 1'b0; dwe = 1'b0; wa = '0; wd = '0; dad = '0; dwd = '0;
        tag = "R9";
        case (op)
            6'b000000: begin
                if (fn == 6'b100000) begin ewe = 1; wa = rd; wd = a + b; tag = "R2"; end
                else if (fn == 6'b100010) begin ewe = 1; wa = rd; wd = a - b; tag = "R2"; end
            end
            6'b001101: begin ewe = 1; wa = rt; wd = a | zx; tag = "R3"; end
            6'b100011: begin
                ea = a + sx; ewe = 1; wa = rt; wd = m_dmem[ea[7:2]]; dad = ea; tag = "R4 R10";
            end
            6'b101011: begin dwe = 1; dad = a + sx; dwd = b; tag = "R5 R10"; end
            6'b000100: begin
                if (a == b) npc = pc4 + {sx[29:0], 2'b00};
                tag = "R6";
            end
            6'b000010: begin npc = {pc4[31:28], ins[25:0], 2'b00}; tag = "R7"; end
            default: tag = "R9";
        endcase
        if (ewe && wa == 5'd0) tag = {tag, " R8"};
        chk(prev_tag, "pc", pc_o, m_pc);
        chk(tag, "rf_we", {31'd0, rf_we_o}, {31'd0, ewe});
        if (ewe) begin
            chk(tag, "rf_waddr", {27'd0, rf_waddr_o}, {27'd0, wa});
            chk(tag, "rf_wdata", rf_wdata_o, wd);
        end
        chk(tag, "dm_we", {31'd0, dm_we_o}, {31'd0, dwe});
        if (op == 6'b100011 || dwe) chk(tag, "dm_addr", dm_addr_o, dad);
        if (dwe) chk(tag, "dm_wdata", dm_wdata_o, dwd);
        if (ewe && wa != 5'd0) m_reg[wa] = wd;
        if (dwe) m_dmem[dad[7:2]] = dwd;
        m_pc     = npc;
        prev_tag = (op == 6'b000100) ? "R6" : (op == 6'b000010) ? "R7" : "R9";
    endtask

    task automatic run(input int cycles);
        for (int c = 0; c < cycles; c++) begin
            step_check();
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240721));
        rst_n   = 1'b0;
        ld_en   = 1'b0;
        ld_addr = '0;
        ld_data = '0;

        // Directed program: corner cases of every instruction.
        for (int i = 0; i < 64; i++) m_imem[i] = NOP_WORD;
        m_imem[0]  = enc_r(5'd10, 5'd11, 5'd9, 6'b100000);     // R1 registers read zero
        m_imem[1]  = enc_i(6'b001101, 5'd0, 5'd1, 16'h8000);   // R3 no sign extension
        m_imem[2]  = enc_i(6'b001101, 5'd0, 5'd2, 16'h0010);
        m_imem[3]  = enc_r(5'd1, 5'd2, 5'd3, 6'b100000);       // R2 add
        m_imem[4]  = enc_r(5'd2, 5'd1, 5'd4, 6'b100010);       // R2 subtract to negative
        m_imem[5]  = enc_i(6'b101011, 5'd2, 5'd3, 16'hFFFC);   // R5 negative offset
        m_imem[6]  = enc_i(6'b100011, 5'd2, 5'd5, 16'hFFFC);   // R4 read back
        m_imem[7]  = enc_i(6'b001101, 5'd0, 5'd0, 16'h1234);   // R8 write to r0
        m_imem[8]  = enc_r(5'd0, 5'd0, 5'd6, 6'b100000);       // R8 r0 still zero
        m_imem[9]  = enc_i(6'b000100, 5'd1, 5'd2, 16'd5);      // R6 not taken
        m_imem[10] = enc_i(6'b000100, 5'd3, 5'd5, 16'd1);      // R6 taken
        m_imem[11] = enc_i(6'b001101, 5'd0, 5'd7, 16'd1);      // skipped
        m_imem[12] = NOP_WORD;                                 // R9 undefined opcode
        m_imem[13] = enc_r(5'd1, 5'd2, 5'd7, 6'b000000);       // R9 undefined function
        m_imem[14] = enc_i(6'b001101, 5'd0, 5'd8, 16'h010C);
        m_imem[15] = enc_i(6'b101011, 5'd8, 5'd4, 16'h0000);   // R10 aliases word 3
        m_imem[16] = enc_i(6'b100011, 5'd0, 5'd12, 16'h000C);  // R10 read alias
        m_imem[17] = enc_j(26'd20);                            // R7 jump
        m_imem[18] = enc_i(6'b001101, 5'd0, 5'd7, 16'd2);
        m_imem[19] = enc_i(6'b001101, 5'd0, 5'd7, 16'd3);
        m_imem[20] = enc_i(6'b000100, 5'd0, 5'd0, 16'hFFFF);   // R6 branch to itself
        reset_and_load();
        run(30);
        chk("R7", "pc parked at jump target", pc_o, 32'd80);
        chk("R10", "aliased store seen by load", m_reg[12], 32'h0000_0010 - 32'h0000_8000);

        // Random programs, each after a fresh reset.
        for (int round = 0; round < 3; round++) begin
            for (int i = 0; i < 64; i++) m_imem[i] = rand_instr();
            reset_and_load();
            run(1500);
        end

        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule